// File: doc/BRIEF.md
# Predicated Segment Load-Broadcast Unit

This block runs one vector "load a segment and replicate it" operation per start pulse. It decodes a 32-bit instruction word, reads the base register, the offset register and the governing predicate through read ports, and forms an effective address. It then issues a single memory read of 16 or 32 bytes, with a per-byte enable that drops every byte of an inactive element.

When the read data returns, inactive elements are forced to zero. The resulting segment is copied across the current vector length in 128-bit lanes, and the destination vector register is written in one cycle. Encodings outside the load-broadcast group, or with a reserved segment kind, end the operation at once with an undefined-encoding flag. A misaligned stack-pointer base ends it with an alignment flag when the check is enabled. Neither case touches memory.

The vector length is given at start as a count of 128-bit lanes, from 1 up to the `MAX_LANES` parameter.

Top module: `seg_bcast_load`

## Requirements
- R1: The form is taken from instruction bits [15:13]. A value of 0 is scalar-plus-scalar. A value of 1 with bit 20 clear is scalar-plus-immediate. Bits [22:21] choose the segment: 00 is 16 bytes and 01 is 32 bytes. Any other form, a form of 1 with bit 20 set, or bits [22:21] of 10 or 11 gives a one-cycle `done` with `undef_err` high, no memory request and no register write.
- R2: The destination index is taken from bits [4:0] and the base index from bits [9:5]. The predicate index is bits [12:10], and the offset index is bits [20:16]. The three source indices appear on the read-port outputs in the same cycle as the instruction.
- R3: In the immediate form, the address is base plus the sign-extended field [19:16] times the segment size (16 or 32 bytes).
- R4: In the scalar form, the address is base plus the offset register shifted left by bits [24:23]. Element sizes are 1, 2, 4 and 8 bytes for codes 0 to 3.
- R5: Byte b of `mem_byte_en` is set only if b is below the segment size and predicate bit (b >> element-size code) is set. Predicate bits at or above the element count have no effect.
- R6: In the written segment, every inactive element is zero whatever the read data holds.
- R7: For a 16-byte segment, every live lane holds the segment. For a 32-byte segment, even lanes hold bytes 0–15 and odd lanes hold bytes 16–31.
- R8: For a 32-byte segment with an odd lane count, the last live lane is written as zero.
- R9: Lanes at or above the vector length are written as zero.
- R10: `mem_req_valid` is held with a stable address until `mem_req_ready` is seen. The register write and `done` come one cycle after the cycle in which `mem_rsp_valid` is sampled. `done` lasts exactly one cycle.
- R11: Base index 31 is the stack pointer. If `align_chk_en` is set and its low four bits are nonzero, the operation ends with `align_err` and no request. An undefined encoding takes priority over this fault. Other base indices, or a clear check enable, never fault.
- R12: After reset no request, no write and no `done` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| instr | input | 32 | Instruction word |
| vl_lanes | input | VL_W | Vector length in 128-bit lanes |
| align_chk_en | input | 1 | Enables the stack-pointer alignment check |
| rs_base_idx | output | 5 | Base register read index |
| rs_off_idx | output | 5 | Offset register read index |
| rs_pred_idx | output | 3 | Predicate register read index |
| base_val | input | ADDR_W | Base register value |
| off_val | input | ADDR_W | Offset register value |
| pred_val | input | 32 | Predicate bits, bit i governs element i |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_addr | output | ADDR_W | Read address |
| mem_byte_en | output | 32 | Per-byte read enable |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 256 | Read data, byte b at address+b |
| wr_en | output | 1 | Vector register write strobe |
| wr_idx | output | 5 | Destination vector register |
| wr_data | output | MAX_LANES*128 | Replicated vector |
| done | output | 1 | Operation finished |
| undef_err | output | 1 | Undefined encoding, valid with done |
| align_err | output | 1 | Stack-pointer misalignment, valid with done |

## Verification
The bench targets odd lane counts with the 32-byte segment, where a design that copies a partial segment leaves half of a segment in the last lane instead of zeros. It also uses predicates with stray bits above the element count, and a read response full of nonzero bytes. Together these expose enables that decode the predicate at the wrong element size, and inactive elements that leak bus data. Negative immediates and an all-ones offset show any sign-extension or scaling slip in the address. Misaligned stack pointers are applied with the check on and off, and on a non-stack base, to catch a fault raised from the wrong condition or a request issued after a fault.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
    localparam int SEG_BYTES = 32;
    localparam int LANE_BITS = 128;
    localparam int SEG_BITS  = SEG_BYTES * 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_WRITE,
        ST_FAULT
    } sbl_state_e;
endpackage

// File: rtl/sbl_decode.sv
module sbl_decode #(
    parameter int ADDR_W = 64
) (
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] off_val,
    output logic [4:0]        zt,
    output logic [4:0]        rn,
    output logic [4:0]        rm,
    output logic [2:0]        pg,
    output logic [1:0]        esz_log2,
    output logic              oct,
    output logic              undef,
    output logic              base_is_sp,
    output logic [ADDR_W-1:0] ea
);
    logic              form_ss;
    logic              form_si;
    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] imm_scaled;
    logic [ADDR_W-1:0] off_scaled;

    always_comb begin
        zt         = instr[4:0];
        rn         = instr[9:5];
        pg         = instr[12:10];
        rm         = instr[20:16];
        esz_log2   = instr[24:23];
        oct        = instr[21];
        form_ss    = (instr[15:13] == 3'd0);
        form_si    = (instr[15:13] == 3'd1) && !instr[20];
        undef      = !(form_ss || form_si) || instr[22];
        base_is_sp = (instr[9:5] == 5'd31);
        imm_ext    = {{(ADDR_W-4){instr[19]}}, instr[19:16]};
        imm_scaled = oct ? (imm_ext << 5) : (imm_ext << 4);
        off_scaled = off_val << esz_log2;
        ea         = base_val + (form_si ? imm_scaled : off_scaled);
    end
endmodule

// File: rtl/sbl_byte_mask.sv
module sbl_byte_mask #(
    parameter  int SEG_BYTES = 32,
    localparam int IDX_W     = $clog2(SEG_BYTES)
) (
    input  logic [SEG_BYTES-1:0] pred,
    input  logic [1:0]           esz_log2,
    input  logic                 oct,
    output logic [SEG_BYTES-1:0] be
);
    for (genvar b = 0; b < SEG_BYTES; b++) begin : g_byte
        logic [IDX_W-1:0] elem;
        logic             in_seg;
        assign elem   = IDX_W'(b) >> esz_log2;
        assign in_seg = oct || (b < SEG_BYTES / 2);
        assign be[b]  = in_seg && pred[elem];
    end
endmodule

// File: rtl/sbl_replicate.sv
module sbl_replicate #(
    parameter  int MAX_LANES = 16,
    localparam int VL_W      = $clog2(MAX_LANES + 1),
    localparam int LANE_W    = 128
) (
    input  logic [2*LANE_W-1:0]         seg,
    input  logic                        oct,
    input  logic [VL_W-1:0]             vl,
    output logic [MAX_LANES*LANE_W-1:0] vec
);
    for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
        logic live;
        logic tail;
        assign live = (VL_W'(l) < vl);
        assign tail = oct && vl[0] && (VL_W'(l + 1) == vl);
        assign vec[l*LANE_W +: LANE_W] = (!live || tail) ? '0 :
            (oct ? seg[(l % 2)*LANE_W +: LANE_W] : seg[LANE_W-1:0]);
    end
endmodule

// File: rtl/seg_bcast_load.sv
module seg_bcast_load
    import sbl_pkg::*;
#(
    parameter  int ADDR_W    = 64,
    parameter  int MAX_LANES = 16,
    localparam int VL_W      = $clog2(MAX_LANES + 1),
    localparam int VEC_W     = MAX_LANES * LANE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [31:0]          instr,
    input  logic [VL_W-1:0]      vl_lanes,
    input  logic                 align_chk_en,
    output logic [4:0]           rs_base_idx,
    output logic [4:0]           rs_off_idx,
    output logic [2:0]           rs_pred_idx,
    input  logic [ADDR_W-1:0]    base_val,
    input  logic [ADDR_W-1:0]    off_val,
    input  logic [SEG_BYTES-1:0] pred_val,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [SEG_BYTES-1:0] mem_byte_en,
    input  logic                 mem_rsp_valid,
    input  logic [SEG_BITS-1:0]  mem_rsp_data,
    output logic                 wr_en,
    output logic [4:0]           wr_idx,
    output logic [VEC_W-1:0]     wr_data,
    output logic                 done,
    output logic                 undef_err,
    output logic                 align_err
);
    typedef struct packed {
        sbl_state_e             st;
        logic [4:0]             zt;
        logic                   oct;
        logic [ADDR_W-1:0]      ea;
        logic [SEG_BYTES-1:0]   be;
        logic [SEG_BITS-1:0]    seg;
        logic [VL_W-1:0]        vl;
        logic                   undef;
        logic                   align;
    } ctx_t;

    ctx_t state_d, state_q;

    logic [4:0]           dec_zt;
    logic [1:0]           dec_esz;
    logic                 dec_oct;
    logic                 dec_undef;
    logic                 dec_sp;
    logic [ADDR_W-1:0]    dec_ea;
    logic [SEG_BYTES-1:0] dec_be;
    logic [VEC_W-1:0]     rep_vec;

    sbl_decode #(.ADDR_W(ADDR_W)) i_decode (
        .instr      (instr),
        .base_val   (base_val),
        .off_val    (off_val),
        .zt         (dec_zt),
        .rn         (rs_base_idx),
        .rm         (rs_off_idx),
        .pg         (rs_pred_idx),
        .esz_log2   (dec_esz),
        .oct        (dec_oct),
        .undef      (dec_undef),
        .base_is_sp (dec_sp),
        .ea         (dec_ea)
    );

    sbl_byte_mask #(.SEG_BYTES(SEG_BYTES)) i_mask (
        .pred     (pred_val),
        .esz_log2 (dec_esz),
        .oct      (dec_oct),
        .be       (dec_be)
    );

    sbl_replicate #(.MAX_LANES(MAX_LANES)) i_repl (
        .seg (state_q.seg),
        .oct (state_q.oct),
        .vl  (state_q.vl),
        .vec (rep_vec)
    );

    always_comb begin
        state_d = state_q;
        case (state_q.st)
            ST_IDLE: begin
                if (start) begin
                    state_d.zt    = dec_zt;
                    state_d.oct   = dec_oct;
                    state_d.ea    = dec_ea;
                    state_d.be    = dec_be;
                    state_d.vl    = vl_lanes;
                    state_d.seg   = '0;
                    state_d.undef = dec_undef;
                    state_d.align = !dec_undef && align_chk_en && dec_sp &&
                                    (base_val[3:0] != 4'd0);
                    state_d.st    = (dec_undef || state_d.align) ? ST_FAULT : ST_REQ;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) state_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    for (int b = 0; b < SEG_BYTES; b++) begin
                        state_d.seg[b*8 +: 8] = state_q.be[b] ? mem_rsp_data[b*8 +: 8] : 8'h00;
                    end
                    state_d.st = ST_WRITE;
                end
            end
            ST_WRITE: state_d.st = ST_IDLE;
            ST_FAULT: state_d.st = ST_IDLE;
            default:  state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign mem_req_valid = (state_q.st == ST_REQ);
    assign mem_addr      = state_q.ea;
    assign mem_byte_en   = state_q.be;
    assign wr_en         = (state_q.st == ST_WRITE);
    assign wr_idx        = state_q.zt;
    assign wr_data       = rep_vec;
    assign done          = (state_q.st == ST_WRITE) || (state_q.st == ST_FAULT);
    assign undef_err     = (state_q.st == ST_FAULT) && state_q.undef;
    assign align_err     = (state_q.st == ST_FAULT) && state_q.align;
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rsp_valid,
    input logic              wr_en,
    input logic              done,
    input logic              undef_err,
    input logic              align_err
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    write_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(mem_rsp_valid));

    // R1
    undef_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_err |-> (done && !wr_en && !mem_req_valid));

    // R11
    fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (done && !undef_err && !wr_en));

    // R12
    req_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(start));
endmodule

bind seg_bcast_load sbl_checker #(.ADDR_W(ADDR_W)) i_sbl_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .wr_en         (wr_en),
    .done          (done),
    .undef_err     (undef_err),
    .align_err     (align_err)
);

// File: tb/test_seg_bcast_load.sv
module test_seg_bcast_load;
    localparam int NL = 16;
    localparam int VW = NL * 128;

    logic           clk = 0;
    logic           rst_n = 0;
    logic           start = 0;
    logic [31:0]    instr = '0;
    logic [4:0]     vl_lanes = 5'd1;
    logic           align_chk_en = 0;
    logic [4:0]     rs_base_idx, rs_off_idx;
    logic [2:0]     rs_pred_idx;
    logic [63:0]    base_val = '0, off_val = '0;
    logic [31:0]    pred_val = '0;
    logic           mem_req_valid, mem_req_ready = 0;
    logic [63:0]    mem_addr;
    logic [31:0]    mem_byte_en;
    logic           mem_rsp_valid = 0;
    logic [255:0]   mem_rsp_data = '0;
    logic           wr_en, done, undef_err, align_err;
    logic [4:0]     wr_idx;
    logic [VW-1:0]  wr_data;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    seg_bcast_load #(.ADDR_W(64), .MAX_LANES(NL)) i_seg_bcast_load (.*);

    typedef struct packed {
        logic [31:0] ins;
        logic [63:0] base;
        logic [63:0] off;
        logic [31:0] pred;
        logic [4:0]  vl;
        logic [63:0] exp_ea;
        logic [31:0] exp_be;
    } row_t;

    function automatic logic [31:0] mk(input logic [2:0] form, input logic [1:0] msz,
                                       input logic [1:0] kind, input logic [4:0] f20,
                                       input logic [2:0] pg, input logic [4:0] rn,
                                       input logic [4:0] zt);
        logic [31:0] w;
        w = '0;
        w[31:25] = 7'b1010010;
        w[24:23] = msz;
        w[22:21] = kind;
        w[20:16] = f20;
        w[15:13] = form;
        w[12:10] = pg;
        w[9:5]   = rn;
        w[4:0]   = zt;
        return w;
    endfunction

    localparam row_t TBL [8] = '{
        '{mk(3'd0, 2'd0, 2'd0, 5'd3,  3'd1, 5'd2,  5'd4),  64'h1000, 64'd5, 32'h0000_FFFF, 5'd2,  64'h1005, 32'h0000_FFFF},
        '{mk(3'd0, 2'd1, 2'd1, 5'd6,  3'd2, 5'd8,  5'd9),  64'h2000, 64'd3, 32'h0000_00A5, 5'd3,  64'h2006, 32'h0000_CC33},
        '{mk(3'd1, 2'd2, 2'd0, 5'h0E, 3'd3, 5'd1,  5'd10), 64'h8000, 64'd0, 32'h0000_0006, 5'd4,  64'h7FE0, 32'h0000_0FF0},
        '{mk(3'd1, 2'd3, 2'd1, 5'h03, 3'd4, 5'd11, 5'd12), 64'h0100, 64'd0, 32'h0000_0009, 5'd4,  64'h0160, 32'hFF00_00FF},
        '{mk(3'd1, 2'd0, 2'd1, 5'h07, 3'd5, 5'd12, 5'd13), 64'h0040, 64'd0, 32'hFFFF_FFFF, 5'd16, 64'h0120, 32'hFFFF_FFFF},
        '{mk(3'd0, 2'd3, 2'd0, 5'd14, 3'd6, 5'd15, 5'd16), 64'h0010, 64'd2, 32'hFFFF_FFF2, 5'd16, 64'h0020, 32'h0000_FF00},
        '{mk(3'd0, 2'd2, 2'd1, 5'd17, 3'd7, 5'd18, 5'd19), 64'h3000, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFF00_0055, 5'd1, 64'h2FFC, 32'h0F0F_0F0F},
        '{mk(3'd0, 2'd0, 2'd0, 5'd20, 3'd0, 5'd31, 5'd21), 64'h5000, 64'd0, 32'h0000_FFFF, 5'd1,  64'h5000, 32'h0000_FFFF}
    };

    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd7;
        return m ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [VW-1:0] model(input logic [63:0] ea, input logic [1:0] msz,
                                            input logic oct, input logic [31:0] pred,
                                            input logic [4:0] vl);
        logic [255:0] seg;
        logic [VW-1:0] v;
        int n;
        int esz;
        seg = '0;
        v = '0;
        n = oct ? 32 : 16;
        esz = 1 << msz;
        for (int b = 0; b < n; b++)
            if (pred[b / esz]) seg[b*8 +: 8] = mem_byte(ea + 64'(b));
        for (int l = 0; l < NL; l++) begin
            if (l < int'(vl)) begin
                if (!oct) v[l*128 +: 128] = seg[127:0];
                else if (!(vl[0] && l == int'(vl) - 1)) v[l*128 +: 128] = seg[(l % 2)*128 +: 128];
            end
        end
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // results of the last operation
    logic          r_req, r_hold, r_done, r_wr, r_uerr, r_aerr, r_after, r_early;
    logic [63:0]   r_addr;
    logic [31:0]   r_be;
    logic [4:0]    r_widx, r_bidx, r_oidx;
    logic [2:0]    r_pidx;
    logic [VW-1:0] r_data;

    task automatic run_op(input logic [31:0] ins, input logic [63:0] b, input logic [63:0] o,
                          input logic [31:0] p, input logic [4:0] v, input logic ce);
        @(negedge clk);
        instr = ins; base_val = b; off_val = o; pred_val = p; vl_lanes = v;
        align_chk_en = ce; start = 1;
        #1;
        r_bidx = rs_base_idx; r_oidx = rs_off_idx; r_pidx = rs_pred_idx;
        @(negedge clk);
        start = 0;
        r_req = 0; r_hold = 0; r_done = 0; r_wr = 0; r_uerr = 0; r_aerr = 0;
        r_early = 0; r_addr = '0; r_be = '0; r_widx = '0; r_data = '0;
        if (done) begin
            r_done = 1; r_wr = wr_en; r_uerr = undef_err; r_aerr = align_err;
            r_req = mem_req_valid;
        end else begin
            r_req = mem_req_valid; r_addr = mem_addr; r_be = mem_byte_en;
            repeat (2) @(negedge clk);
            r_hold = mem_req_valid && (mem_addr == r_addr);
            mem_req_ready = 1;
            @(negedge clk);
            mem_req_ready = 0;
            @(negedge clk);
            r_early = done;
            for (int k = 0; k < 32; k++) mem_rsp_data[k*8 +: 8] = mem_byte(r_addr + 64'(k));
            mem_rsp_valid = 1;
            @(negedge clk);
            mem_rsp_valid = 0;
            r_done = done; r_wr = wr_en; r_data = wr_data; r_widx = wr_idx;
            r_uerr = undef_err; r_aerr = align_err;
        end
        @(negedge clk);
        r_after = done || mem_req_valid;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "req in reset", VW'(mem_req_valid), '0);
        chk("R12", "done in reset", VW'(done), '0);
        rst_n = 1;
        @(negedge clk);
        chk("R12", "outputs after reset", VW'({mem_req_valid, wr_en, done}), '0);

        foreach (TBL[i]) begin
            logic oct;
            string dtag;
            oct = TBL[i].ins[21];
            run_op(TBL[i].ins, TBL[i].base, TBL[i].off, TBL[i].pred, TBL[i].vl, 1'b1);
            chk("R2", "base idx", VW'(r_bidx), VW'(TBL[i].ins[9:5]));
            chk("R2", "off idx", VW'(r_oidx), VW'(TBL[i].ins[20:16]));
            chk("R2", "pred idx", VW'(r_pidx), VW'(TBL[i].ins[12:10]));
            chk(TBL[i].ins[13] ? "R3" : "R4", "address", VW'(r_addr), VW'(TBL[i].exp_ea));
            chk("R5", "byte enables", VW'(r_be), VW'(TBL[i].exp_be));
            chk("R10", "request held", VW'(r_hold), VW'(1'b1));
            chk("R10", "write timing", VW'({r_early, r_done, r_wr}), VW'(3'b011));
            chk("R10", "done single", VW'(r_after), '0);
            chk("R2", "dest idx", VW'(r_widx), VW'(TBL[i].ins[4:0]));
            if (oct && TBL[i].vl[0])      dtag = "R8";
            else if (TBL[i].vl != 5'd16)  dtag = "R9";
            else if (TBL[i].pred != '1)   dtag = "R6";
            else                          dtag = "R7";
            chk(dtag, "vector data", r_data,
                model(TBL[i].exp_ea, TBL[i].ins[24:23], oct, TBL[i].pred, TBL[i].vl));
        end

        // R1 reserved segment kind 10
        run_op(mk(3'd0, 2'd0, 2'd2, 5'd1, 3'd0, 5'd1, 5'd1), 64'h100, 64'd0, '1, 5'd2, 1'b0);
        chk("R1", "kind 10 flags", VW'({r_done, r_uerr, r_aerr, r_wr, r_req}), VW'(5'b11000));
        chk("R1", "kind 10 quiet", VW'(r_after), '0);
        // R1 reserved segment kind 11
        run_op(mk(3'd1, 2'd1, 2'd3, 5'd1, 3'd0, 5'd1, 5'd1), 64'h100, 64'd0, '1, 5'd2, 1'b0);
        chk("R1", "kind 11 flags", VW'({r_done, r_uerr, r_wr, r_req}), VW'(4'b1100));
        // R1 form outside group
        run_op(mk(3'd2, 2'd0, 2'd0, 5'd1, 3'd0, 5'd1, 5'd1), 64'h100, 64'd0, '1, 5'd2, 1'b0);
        chk("R1", "form 2 flags", VW'({r_done, r_uerr, r_wr, r_req}), VW'(4'b1100));
        // R1 immediate form with bit 20 set
        run_op(mk(3'd1, 2'd0, 2'd0, 5'h11, 3'd0, 5'd1, 5'd1), 64'h100, 64'd0, '1, 5'd2, 1'b0);
        chk("R1", "bit20 flags", VW'({r_done, r_uerr, r_wr, r_req}), VW'(4'b1100));
        // R11 misaligned stack pointer, check on
        run_op(mk(3'd0, 2'd0, 2'd0, 5'd0, 3'd0, 5'd31, 5'd2), 64'h5008, 64'd0, '1, 5'd1, 1'b1);
        chk("R11", "sp fault", VW'({r_done, r_aerr, r_uerr, r_wr, r_req}), VW'(5'b11000));
        chk("R11", "sp fault quiet", VW'(r_after), '0);
        // R11 misaligned stack pointer, check off
        run_op(mk(3'd0, 2'd0, 2'd0, 5'd0, 3'd0, 5'd31, 5'd2), 64'h5008, 64'd0, '1, 5'd1, 1'b0);
        chk("R11", "check off proceeds", VW'({r_req, r_wr, r_aerr}), VW'(3'b110));
        chk("R11", "check off address", VW'(r_addr), VW'(64'h5008));
        // R11 misaligned non-stack base
        run_op(mk(3'd0, 2'd0, 2'd0, 5'd0, 3'd0, 5'd7, 5'd2), 64'h5008, 64'd0, '1, 5'd1, 1'b1);
        chk("R11", "non-sp proceeds", VW'({r_req, r_wr, r_aerr}), VW'(3'b110));
        // R11 undefined takes priority over misalignment
        run_op(mk(3'd0, 2'd0, 2'd2, 5'd0, 3'd0, 5'd31, 5'd2), 64'h5008, 64'd0, '1, 5'd1, 1'b1);
        chk("R11", "undef priority", VW'({r_uerr, r_aerr, r_req}), VW'(3'b100));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule